// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches the CPU address bus and raises a break request when an opcode fetch lands on a break address that software has programmed. Software loads the target address one byte at a time through a small byte-wide register port, sets an enable bit, and waits. When a qualified fetch matches both address bytes, the unit sets a break-active flag. That flag drives the break request toward the system integration logic and a freeze output that halts a companion timer counter.

The break handler ends the break state by writing 0 to the flag. A separate clear-enable bit gates that write: while the bit is 0, clear attempts made during the break are dropped. A re-arm rule governs breaking again. If the handler clears the flag without touching the address registers, a later fetch at the same address does not break. Any write to either address byte, even one that stores the same value, re-arms the comparator, so the handler can break continuously by loading the next address before it clears the flag.

The register map has one select value per address byte, a control register and a clear-enable register. All read-back is combinational.

Top module: `brkpt_unit`

## Requirements
- R1: After a synchronous reset the address bytes, the enable bit, the flag and the clear-enable bit all read 0, and `break_req` and `timer_freeze` are both 0.
- R2: With the enable set, a cycle in which `fetch_strobe` is 1 and `bus_addr[15:8]` and `bus_addr[7:0]` equal the high and low address bytes sets the flag on the next clock edge. A mismatch in either byte sets nothing.
- R3: While the enable bit (control bit 7) is 0, no fetch sets the flag.
- R4: An address match with `fetch_strobe` at 0 sets nothing.
- R5: `timer_freeze` is 1 exactly while the flag is 1, and it falls in the same cycle as `break_req` when the flag is cleared.
- R6: A control write with bit 6 at 0 clears the flag only when clear-enable (bit 0 at select 3) is 1. Otherwise the flag stays set.
- R7: After the flag is cleared with no address byte written since the break began, a later matching fetch at that address does not set the flag.
- R8: Writing a new low byte re-arms the comparator, and a matching fetch on the new address breaks again.
- R9: A control write with bit 6 at 1 never sets the flag.
- R10: Reads return current state: select 0 gives the high byte, select 1 the low byte, select 2 gives {enable, flag, 6'b0}, and select 3 gives {7'b0, clear-enable}.
- R11: Rewriting the high byte with its unchanged value also re-arms the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address bus |
| fetch_strobe | input | 1 | One-cycle opcode-fetch qualifier |
| reg_sel | input | 2 | Register select: 0 high byte, 1 low byte, 2 control, 3 clear-enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register |
| break_req | output | 1 | Break request to the system integration logic |
| timer_freeze | output | 1 | Halts the timer counter while the break is active |

## Verification
If the suppression latch or the address-written tracker holds the wrong value, the only sign at the ports is a break that appears or goes missing on the first matching fetch after the flag is cleared. The error cannot be seen earlier, so the bench issues a matching fetch right after each clear and each address rewrite. A wrong flag shows on `break_req`, `timer_freeze` and control read-back one edge after its cause. The reference model compares all three on every cycle, so a divergence is caught within one clock.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
    localparam int BYTE_W        = 8;
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_FLAG_BIT = 6;
    localparam int FCTL_CLR_BIT  = 0;

    typedef logic [BYTE_W-1:0] byte_t;

    // decoded register-port intent, one cycle wide
    typedef struct packed {
        logic addr_wr;    // any address byte written
        logic clear_try;  // control write with flag bit at 0
    } reg_evt_t;

    // state carried by the break sequencer
    typedef struct packed {
        logic flag;
        logic dirty;
        logic supp;
    } brk_state_t;

    function automatic byte_t pack_ctrl(input logic en, input logic flag);
        byte_t v;
        v = '0;
        v[CTRL_EN_BIT]   = en;
        v[CTRL_FLAG_BIT] = flag;
        return v;
    endfunction

    function automatic byte_t pack_fctl(input logic clr_en);
        byte_t v;
        v = '0;
        v[FCTL_CLR_BIT] = clr_en;
        return v;
    endfunction
endpackage

// File: rtl/brkpt_regs.sv
module brkpt_regs
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  byte_t             reg_wdata,
    input  logic              flag,
    output logic [ADDR_W-1:0] brk_addr,
    output logic              ctl_en,
    output logic              clr_en,
    output byte_t             reg_rdata,
    output reg_evt_t          evt
);
    localparam int NBYTES   = ADDR_W / BYTE_W;
    localparam int CTRL_SEL = NBYTES;
    localparam int FCTL_SEL = NBYTES + 1;

    logic [NBYTES-1:0] byte_hit;
    byte_t             byte_rd [NBYTES];

    // select i holds the byte counted from the most significant end
    for (genvar i = 0; i < NBYTES; i++) begin : g_abyte
        localparam int HI = ADDR_W - 1 - i * BYTE_W;
        assign byte_hit[i] = reg_wr && (int'(reg_sel) == i);
        always_ff @(posedge clk) begin
            if (rst)              brk_addr[HI -: BYTE_W] <= '0;
            else if (byte_hit[i]) brk_addr[HI -: BYTE_W] <= reg_wdata;
        end
        assign byte_rd[i] = brk_addr[HI -: BYTE_W];
    end

    logic ctrl_wr, fctl_wr;
    assign ctrl_wr = reg_wr && (int'(reg_sel) == CTRL_SEL);
    assign fctl_wr = reg_wr && (int'(reg_sel) == FCTL_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en <= 1'b0;
            clr_en <= 1'b0;
        end else begin
            if (ctrl_wr) ctl_en <= reg_wdata[CTRL_EN_BIT];
            if (fctl_wr) clr_en <= reg_wdata[FCTL_CLR_BIT];
        end
    end

    always_comb begin
        evt.addr_wr   = |byte_hit;
        evt.clear_try = ctrl_wr && !reg_wdata[CTRL_FLAG_BIT];
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_sel) == CTRL_SEL)      reg_rdata = pack_ctrl(ctl_en, flag);
        else if (int'(reg_sel) == FCTL_SEL) reg_rdata = pack_fctl(clr_en);
        else begin
            for (int k = 0; k < NBYTES; k++)
                if (int'(reg_sel) == k) reg_rdata = byte_rd[k];
        end
    end
endmodule

// File: rtl/brkpt_compare.sv
module brkpt_compare
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic              fetch_strobe,
    input  logic              ctl_en,
    input  logic              supp,
    output logic              hit
);
    localparam int NBYTES = ADDR_W / BYTE_W;

    logic [NBYTES-1:0] eq;

    // one byte-wide comparator per address byte
    for (genvar i = 0; i < NBYTES; i++) begin : g_cmp
        assign eq[i] = bus_addr[i*BYTE_W +: BYTE_W] == brk_addr[i*BYTE_W +: BYTE_W];
    end

    assign hit = ctl_en && fetch_strobe && !supp && (&eq);
endmodule

// File: rtl/brkpt_state.sv
module brkpt_state
    import brkpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       clr_en,
    input  reg_evt_t   evt,
    output brk_state_t st
);
    brk_state_t nx;
    logic       clr_ok;

    assign clr_ok = evt.clear_try && st.flag && clr_en;

    always_comb begin
        nx = st;
        nx.flag = hit || (st.flag && !clr_ok);
        // address-written tracker: set by a write, dropped when a break begins
        if (evt.addr_wr)           nx.dirty = 1'b1;
        else if (hit && !st.flag)  nx.dirty = 1'b0;
        // suppression: a write re-arms, a clear with no write since the break disarms
        if (evt.addr_wr)           nx.supp = 1'b0;
        else if (clr_ok && !hit)   nx.supp = !st.dirty;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end
endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              fetch_strobe,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              break_req,
    output logic              timer_freeze
);
    logic [ADDR_W-1:0] brk_addr;
    logic              ctl_en, clr_en, hit;
    reg_evt_t          evt;
    brk_state_t        st;

    brkpt_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .flag(st.flag), .brk_addr(brk_addr),
        .ctl_en(ctl_en), .clr_en(clr_en), .reg_rdata(reg_rdata), .evt(evt)
    );

    brkpt_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .bus_addr(bus_addr), .brk_addr(brk_addr), .fetch_strobe(fetch_strobe),
        .ctl_en(ctl_en), .supp(st.supp), .hit(hit)
    );

    brkpt_state u_state (
        .clk(clk), .rst(rst), .hit(hit), .clr_en(clr_en), .evt(evt), .st(st)
    );

    assign break_req    = st.flag;
    assign timer_freeze = st.flag;
endmodule

// File: rtl/brkpt_checker.sv
module brkpt_checker #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              fetch_strobe,
    input logic [SEL_W-1:0]  reg_sel,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic              break_req,
    input logic              timer_freeze,
    input logic [ADDR_W-1:0] brk_addr,
    input logic              ctl_en,
    input logic              clr_en,
    input logic              supp
);
    localparam int CTRL_SEL = ADDR_W / 8;

    p_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(break_req) |-> $past(bus_addr == brk_addr));

    p_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(break_req) |-> $past(ctl_en));

    p_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(break_req) |-> $past(fetch_strobe));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(break_req) |-> $fell(timer_freeze));

    p_clear_gated_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(break_req) |-> $past(reg_wr && int'(reg_sel) == CTRL_SEL && !reg_wdata[6] && clr_en));

    p_suppressed_r7: assert property (@(posedge clk) disable iff (rst)
        supp |=> !$rose(break_req));
endmodule

bind brkpt_unit brkpt_checker #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .fetch_strobe(fetch_strobe),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .break_req(break_req), .timer_freeze(timer_freeze), .brk_addr(brk_addr),
    .ctl_en(ctl_en), .clr_en(clr_en), .supp(st.supp)
);

// File: tb/sim_brkpt_unit.sv
module sim_brkpt_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        fetch_strobe = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        break_req, timer_freeze;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    brkpt_unit u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .fetch_strobe(fetch_strobe),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .break_req(break_req), .timer_freeze(timer_freeze)
    );

    always #2 clk = ~clk;  // 250 MHz

    // behavioural reference model
    logic [7:0] m_hi, m_lo;
    bit m_en, m_flag, m_clren, m_written, m_blocked;

    always @(posedge clk) begin
        bit match, cleared, addrw;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_en = 0; m_flag = 0; m_clren = 0;
            m_written = 0; m_blocked = 0;
        end else begin
            match   = m_en && fetch_strobe && !m_blocked && bus_addr == {m_hi, m_lo};
            addrw   = reg_wr && reg_sel < 2;
            cleared = reg_wr && reg_sel == 2 && reg_wdata[6] == 0 && m_flag && m_clren;
            if (addrw) begin m_written = 1; m_blocked = 0; end
            else begin
                if (cleared && !match) m_blocked = !m_written;
                if (match && !m_flag) m_written = 0;
            end
            if (match) m_flag = 1;
            else if (cleared) m_flag = 0;
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: m_hi = reg_wdata;
                    2'd1: m_lo = reg_wdata;
                    2'd2: m_en = reg_wdata[7];
                    default: m_clren = reg_wdata[0];
                endcase
            end
        end
    end

    function automatic logic [7:0] m_read(input logic [1:0] s);
        case (s)
            2'd0: return m_hi;
            2'd1: return m_lo;
            2'd2: return {m_en, m_flag, 6'b0};
            default: return {7'b0, m_clren};
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            chk(break_req == m_flag, "R2 break_req vs model", break_req, m_flag);
            chk(timer_freeze == m_flag, "R5 timer_freeze vs model", timer_freeze, m_flag);
            chk(reg_rdata == m_read(reg_sel), "R10 read vs model", reg_rdata, m_read(reg_sel));
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic fetch(input logic [15:0] a, input bit strobe);
        @(negedge clk); bus_addr = a; fetch_strobe = strobe;
        @(negedge clk); fetch_strobe = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk); reg_sel = s; #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic out_is(input bit exp, input string tag);
        chk(break_req == exp, tag, break_req, exp);
        chk(timer_freeze == exp, tag, timer_freeze, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        out_is(0, "R1 outputs after reset");
        for (int s = 0; s < 4; s++) rd(s[1:0], 8'h00, "R1 register reset value");

        wr(0, 8'h12); wr(1, 8'h34);
        rd(0, 8'h12, "R10 high byte"); rd(1, 8'h34, "R10 low byte");

        fetch(16'h1234, 1); out_is(0, "R3 disabled no break");
        wr(2, 8'h80); rd(2, 8'h80, "R10 control enable");
        fetch(16'h1235, 1); out_is(0, "R2 low byte mismatch");
        fetch(16'h1334, 1); out_is(0, "R2 high byte mismatch");
        fetch(16'h1234, 0); out_is(0, "R4 no fetch strobe");
        fetch(16'h1234, 1); out_is(1, "R2 match breaks");
        rd(2, 8'hC0, "R10 control flag");

        wr(2, 8'h80); out_is(1, "R6 clear ignored with clear-enable 0");
        wr(3, 8'h01); rd(3, 8'h01, "R10 clear-enable read");
        wr(2, 8'h80); out_is(0, "R5 freeze drops with flag");
        fetch(16'h1234, 1); out_is(0, "R7 same address suppressed");
        wr(2, 8'hC0); out_is(0, "R9 writing 1 does not set flag");

        wr(1, 8'h40); fetch(16'h1240, 1); out_is(1, "R8 new address breaks");
        wr(2, 8'h80); out_is(0, "R8 cleared");
        fetch(16'h1240, 1); out_is(0, "R7 suppressed after clear");
        wr(0, 8'h12); fetch(16'h1240, 1); out_is(1, "R11 same-value rewrite re-arms");
        wr(2, 8'h80); out_is(0, "R11 cleared");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule